// File: doc/BRIEF.md
# UART Response Frame Builder

This block turns the outcome of one serial command into the byte stream of its response frame. When the command decoder has finished an operation, it presents one request. The request carries a success or error flag, the operation type, the length field of the command, the bytes read from memory or an error code, and whether the command used a checksum. The builder captures the request and emits the frame one byte at a time to a UART transmitter, over a valid/ready byte interface.

A frame contains the following bytes, in order. First comes an optional run of filler bytes that helps the far end find byte alignment. Then come the start byte, an optional target-address byte and a response control byte. Next comes the data section: the read bytes, a write acknowledge or an error code. After that comes an optional CRC-16, and finally the end byte. The start byte, end byte, target byte, filler byte and filler count are parameters shared with the command side of the link. A one-cycle completion pulse tells the decoder that it may send the next request.

Top module: `resp_frame_builder`

## Requirements
- R1: After reset, `tx_valid` and `done` are low and `req_ready` is high.
- R2: A frame is emitted in this order: PRE_COUNT filler bytes, the start byte (0x68 by default), the target byte (0xAD by default, only when TARGET_EN=1), the control byte, the data section, the CRC bytes (only when enabled) and the end byte (0x16 by default).
- R3: In the control byte, bit 7 is the error flag and bits 6:5 are 0. Bits 4:0 hold the requested length minus one for a successful read, and 0 for an error or a write acknowledge.
- R4: A successful read sends `req_len`+1 data bytes, taken from `req_data` starting at bits 7:0 and rising one byte at a time.
- R5: A successful write sends one data byte, the acknowledge value ACK_BYTE (0xAC by default).
- R6: An error sends one data byte equal to `req_code`, whatever the operation type is.
- R7: When `req_crc_en` is 1, a CRC-16 is inserted before the end byte, low byte first. It uses polynomial 0x1021, initial value 0xFFFF, no bit reflection and no final XOR. It is computed over the start byte, target byte, control byte and data bytes. When `req_crc_en` is 0, no CRC bytes are sent.
- R8: The filler bytes (PRE_BYTE, 0xFE by default) are not included in the CRC. With PRE_COUNT=0 (the default), no filler bytes are sent.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged in the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the end byte is accepted. `tx_valid` is low in that cycle.
- R11: The request is captured in the cycle that `req_valid` and `req_ready` are both high. While a frame is in progress, `req_ready` is low, and new requests or changes to `req_data` have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A response request is presented |
| req_ready | output | 1 | Builder is idle and accepts a request |
| req_err | input | 1 | Operation failed |
| req_wr | input | 1 | Operation was a write (1) or a read (0) |
| req_len | input | $clog2(MAX_DATA) | Command length field (byte count minus one) |
| req_code | input | 8 | Error code sent when `req_err` is 1 |
| req_crc_en | input | 1 | Command carried a CRC; append one to the response |
| req_data | input | MAX_DATA*8 | Read bytes, byte 0 in bits 7:0 |
| tx_data | output | 8 | Frame byte toward the transmitter |
| tx_valid | output | 1 | `tx_data` holds a frame byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| done | output | 1 | One-cycle pulse after the end byte is accepted |

## Verification
The bench targets the following corner cases:
- **Longest read (32 bytes).** A length counter that is one bit too narrow or off by one would drop or repeat a byte, and the frame would no longer match.
- **An error on a write command.** If the acknowledge branch took priority, the error code would be replaced by 0xAC. If the length field were not cleared, the control byte would still carry the command's length.
- **Filler bytes together with a CRC.** An instance with filler bytes and no target byte shows whether the fillers leak into the CRC or whether the missing target byte breaks the ordering.
- **Stalls and captured inputs.** Random transmitter stalls expose a byte that changes while it is held. A second request and altered read data, injected mid-frame, expose a builder that re-captures its inputs while busy.

// File: rtl/resp_pkg.sv
`timescale 1ns/1ps
package resp_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,
        PH_START,
        PH_TGT,
        PH_CTRL,
        PH_DATA,
        PH_CRC_LO,
        PH_CRC_HI,
        PH_END
    } phase_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

endpackage

// File: rtl/resp_crc16_step.sv
`timescale 1ns/1ps
module resp_crc16_step #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    // One byte folded in, MSB first, no reflection.
    always_comb begin
        logic [15:0] acc;
        acc = crc_i ^ {byte_i, 8'h00};
        for (int b = 0; b < 8; b++) begin
            if (acc[15]) acc = {acc[14:0], 1'b0} ^ POLY;
            else         acc = {acc[14:0], 1'b0};
        end
        crc_o = acc;
    end
endmodule

// File: rtl/resp_byte_mux.sv
`timescale 1ns/1ps
module resp_byte_mux
    import resp_pkg::*;
#(
    parameter int          MAX_DATA    = 32,
    parameter logic [7:0]  PRE_BYTE    = 8'hFE,
    parameter logic [7:0]  START_BYTE  = 8'h68,
    parameter logic [7:0]  TARGET_BYTE = 8'hAD,
    parameter logic [7:0]  END_BYTE    = 8'h16,
    parameter logic [7:0]  ACK_BYTE    = 8'hAC,
    localparam int         LEN_W       = $clog2(MAX_DATA),
    localparam int         DW          = MAX_DATA * 8
) (
    input  phase_e             phase_i,
    input  logic [LEN_W-1:0]   idx_i,
    input  logic               err_i,
    input  logic               wr_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [7:0]         code_i,
    input  logic [DW-1:0]      data_i,
    input  logic [15:0]        crc_i,
    output logic [7:0]         byte_o
);
    logic [7:0] ctrl_byte;
    logic [7:0] data_byte;
    logic       single;

    assign single = err_i | wr_i;

    always_comb begin
        ctrl_byte      = 8'h00;
        ctrl_byte[7]   = err_i;
        ctrl_byte[4:0] = single ? 5'd0 : 5'(len_i);
    end

    always_comb begin
        if (err_i)     data_byte = code_i;
        else if (wr_i) data_byte = ACK_BYTE;
        else           data_byte = data_i[idx_i*8 +: 8];
    end

    always_comb begin
        unique case (phase_i)
            PH_PRE:    byte_o = PRE_BYTE;
            PH_START:  byte_o = START_BYTE;
            PH_TGT:    byte_o = TARGET_BYTE;
            PH_CTRL:   byte_o = ctrl_byte;
            PH_DATA:   byte_o = data_byte;
            PH_CRC_LO: byte_o = crc_i[7:0];
            PH_CRC_HI: byte_o = crc_i[15:8];
            PH_END:    byte_o = END_BYTE;
            default:   byte_o = 8'h00;
        endcase
    end

    // R3
    always_comb begin
        if (phase_i == PH_CTRL && err_i) begin
            err_ctrl_chk: assert (byte_o == 8'h80);
        end
    end

    // R6
    always_comb begin
        if (phase_i == PH_DATA && err_i) begin
            err_code_chk: assert (byte_o == code_i);
        end
    end
endmodule

// File: rtl/resp_seq.sv
`timescale 1ns/1ps
module resp_seq
    import resp_pkg::*;
#(
    parameter int  MAX_DATA  = 32,
    parameter int  PRE_COUNT = 0,
    parameter bit  TARGET_EN = 1'b1,
    localparam int LEN_W     = $clog2(MAX_DATA),
    localparam int DW        = MAX_DATA * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_err_i,
    input  logic             req_wr_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [7:0]       req_code_i,
    input  logic             req_crc_en_i,
    input  logic [DW-1:0]    req_data_i,
    input  logic [7:0]       tx_byte_i,
    input  logic             tx_ready_i,
    output logic             tx_valid_o,
    output phase_e           phase_o,
    output logic [LEN_W-1:0] idx_o,
    output logic             err_o,
    output logic             wr_o,
    output logic [LEN_W-1:0] len_o,
    output logic [7:0]       code_o,
    output logic [DW-1:0]    data_o,
    output logic [15:0]      crc_o,
    output logic             done_o
);
    localparam int PRE_W = (PRE_COUNT > 1) ? $clog2(PRE_COUNT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'((PRE_COUNT > 0) ? PRE_COUNT - 1 : 0);

    typedef struct packed {
        phase_e             phase;
        logic [PRE_W-1:0]   pre;
        logic [LEN_W-1:0]   idx;
        logic               err;
        logic               wr;
        logic               crc_en;
        logic [LEN_W-1:0]   len;
        logic [7:0]         code;
        logic [DW-1:0]      data;
        logic [15:0]        crc;
        logic               done;
    } seq_t;

    seq_t s_q, s_d;

    logic [15:0]      crc_nx;
    logic             fire;
    logic [LEN_W-1:0] last_idx;
    phase_e           after_start;
    phase_e           after_data;
    phase_e           first_phase;

    resp_crc16_step #(.POLY(CRC_POLY)) crc_u (
        .crc_i  (s_q.crc),
        .byte_i (tx_byte_i),
        .crc_o  (crc_nx)
    );

    generate
        if (TARGET_EN) begin : g_tgt
            assign after_start = PH_TGT;
        end else begin : g_no_tgt
            assign after_start = PH_CTRL;
        end
        if (PRE_COUNT > 0) begin : g_pre
            assign first_phase = PH_PRE;
        end else begin : g_no_pre
            assign first_phase = PH_START;
        end
    endgenerate

    assign fire       = (s_q.phase != PH_IDLE) && tx_ready_i;
    assign last_idx   = (s_q.err || s_q.wr) ? '0 : s_q.len;
    assign after_data = s_q.crc_en ? PH_CRC_LO : PH_END;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    s_d.phase  = first_phase;
                    s_d.pre    = '0;
                    s_d.idx    = '0;
                    s_d.err    = req_err_i;
                    s_d.wr     = req_wr_i;
                    s_d.crc_en = req_crc_en_i;
                    s_d.len    = req_len_i;
                    s_d.code   = req_code_i;
                    s_d.data   = req_data_i;
                    s_d.crc    = CRC_INIT;
                end
            end
            PH_PRE: begin
                if (fire) begin
                    if (s_q.pre == PRE_LAST) s_d.phase = PH_START;
                    else                     s_d.pre   = s_q.pre + 1'b1;
                end
            end
            PH_START: begin
                if (fire) begin
                    s_d.crc   = crc_nx;
                    s_d.phase = after_start;
                end
            end
            PH_TGT: begin
                if (fire) begin
                    s_d.crc   = crc_nx;
                    s_d.phase = PH_CTRL;
                end
            end
            PH_CTRL: begin
                if (fire) begin
                    s_d.crc   = crc_nx;
                    s_d.idx   = '0;
                    s_d.phase = PH_DATA;
                end
            end
            PH_DATA: begin
                if (fire) begin
                    s_d.crc = crc_nx;
                    if (s_q.idx == last_idx) s_d.phase = after_data;
                    else                     s_d.idx   = s_q.idx + 1'b1;
                end
            end
            PH_CRC_LO: begin
                if (fire) s_d.phase = PH_CRC_HI;
            end
            PH_CRC_HI: begin
                if (fire) s_d.phase = PH_END;
            end
            PH_END: begin
                if (fire) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready_o = (s_q.phase == PH_IDLE);
    assign tx_valid_o  = (s_q.phase != PH_IDLE);
    assign phase_o     = s_q.phase;
    assign idx_o       = s_q.idx;
    assign err_o       = s_q.err;
    assign wr_o        = s_q.wr;
    assign len_o       = s_q.len;
    assign code_o      = s_q.code;
    assign data_o      = s_q.data;
    assign crc_o       = s_q.crc;
    assign done_o      = s_q.done;

    // R11
    busy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> ($stable(s_q.err) && $stable(s_q.wr) &&
                                     $stable(s_q.len) && $stable(s_q.data) &&
                                     $stable(s_q.code) && $stable(s_q.crc_en)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R5
    single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DATA && (s_q.err || s_q.wr)) |-> (s_q.idx == '0));

    // R7
    crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_CRC_LO || s_q.phase == PH_CRC_HI) |=> $stable(s_q.crc));
endmodule

// File: rtl/resp_frame_builder.sv
`timescale 1ns/1ps
module resp_frame_builder
    import resp_pkg::*;
#(
    parameter int         MAX_DATA    = 32,
    parameter int         PRE_COUNT   = 0,
    parameter logic [7:0] PRE_BYTE    = 8'hFE,
    parameter logic [7:0] START_BYTE  = 8'h68,
    parameter bit         TARGET_EN   = 1'b1,
    parameter logic [7:0] TARGET_BYTE = 8'hAD,
    parameter logic [7:0] END_BYTE    = 8'h16,
    parameter logic [7:0] ACK_BYTE    = 8'hAC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_err,
    input  logic                        req_wr,
    input  logic [$clog2(MAX_DATA)-1:0] req_len,
    input  logic [7:0]                  req_code,
    input  logic                        req_crc_en,
    input  logic [MAX_DATA*8-1:0]       req_data,
    output logic [7:0]                  tx_data,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic                        done
);
    localparam int LEN_W = $clog2(MAX_DATA);
    localparam int DW    = MAX_DATA * 8;

    phase_e           phase;
    logic [LEN_W-1:0] idx;
    logic             err;
    logic             wr;
    logic [LEN_W-1:0] len;
    logic [7:0]       code;
    logic [DW-1:0]    data;
    logic [15:0]      crc;

    resp_seq #(
        .MAX_DATA  (MAX_DATA),
        .PRE_COUNT (PRE_COUNT),
        .TARGET_EN (TARGET_EN)
    ) seq_u (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_err_i    (req_err),
        .req_wr_i     (req_wr),
        .req_len_i    (req_len),
        .req_code_i   (req_code),
        .req_crc_en_i (req_crc_en),
        .req_data_i   (req_data),
        .tx_byte_i    (tx_data),
        .tx_ready_i   (tx_ready),
        .tx_valid_o   (tx_valid),
        .phase_o      (phase),
        .idx_o        (idx),
        .err_o        (err),
        .wr_o         (wr),
        .len_o        (len),
        .code_o       (code),
        .data_o       (data),
        .crc_o        (crc),
        .done_o       (done)
    );

    resp_byte_mux #(
        .MAX_DATA    (MAX_DATA),
        .PRE_BYTE    (PRE_BYTE),
        .START_BYTE  (START_BYTE),
        .TARGET_BYTE (TARGET_BYTE),
        .END_BYTE    (END_BYTE),
        .ACK_BYTE    (ACK_BYTE)
    ) mux_u (
        .phase_i (phase),
        .idx_i   (idx),
        .err_i   (err),
        .wr_i    (wr),
        .len_i   (len),
        .code_i  (code),
        .data_i  (data),
        .crc_i   (crc),
        .byte_o  (tx_data)
    );

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_valid);

    // R2
    end_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && phase == PH_END) |=> done);
endmodule

// File: tb/resp_frame_builder_test.sv
`timescale 1ns/1ps
module resp_frame_builder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         rv_m = 1'b0, rv_p = 1'b0;
    logic         rr_m, rr_p;
    logic         r_err = 1'b0, r_wr = 1'b0, r_crc = 1'b0;
    logic [4:0]   r_len = '0;
    logic [7:0]   r_code = '0;
    logic [255:0] r_data = '0;
    logic [7:0]   td_m, td_p;
    logic         tv_m, tv_p, dn_m, dn_p;
    logic         t_rdy = 1'b0;

    resp_frame_builder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv_m), .req_ready(rr_m),
        .req_err(r_err), .req_wr(r_wr), .req_len(r_len), .req_code(r_code),
        .req_crc_en(r_crc), .req_data(r_data), .tx_data(td_m), .tx_valid(tv_m),
        .tx_ready(t_rdy), .done(dn_m));

    resp_frame_builder #(.PRE_COUNT(2), .TARGET_EN(1'b0)) uut_pre (
        .clk(clk), .rst_n(rst_n), .req_valid(rv_p), .req_ready(rr_p),
        .req_err(r_err), .req_wr(r_wr), .req_len(r_len), .req_code(r_code),
        .req_crc_en(r_crc), .req_data(r_data), .tx_data(td_p), .tx_valid(tv_p),
        .tx_ready(t_rdy), .done(dn_p));

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_b [0:63];
    logic [7:0] got_b [0:63];
    int exp_n, got_n;
    logic [15:0] lfsr = 16'hACE1;

    // fields: err, wr, crc_en, len[4:0], pad[3:0], code[7:0], seed[7:0]
    localparam int NV = 9;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 1'b1, 5'd3,  4'h0, 8'h00, 8'h10},
        {1'b0, 1'b0, 1'b0, 5'd0,  4'h0, 8'h00, 8'h5A},
        {1'b0, 1'b0, 1'b1, 5'd31, 4'h0, 8'h00, 8'h01},
        {1'b0, 1'b1, 1'b1, 5'd3,  4'h0, 8'h00, 8'h22},
        {1'b0, 1'b1, 1'b0, 5'd7,  4'h0, 8'h00, 8'h33},
        {1'b1, 1'b0, 1'b1, 5'd4,  4'h0, 8'hE1, 8'h44},
        {1'b1, 1'b1, 1'b0, 5'd2,  4'h0, 8'hE3, 8'h55},
        {1'b1, 1'b0, 1'b1, 5'd9,  4'h0, 8'hE4, 8'h66},
        {1'b0, 1'b0, 1'b0, 5'd15, 4'h0, 8'h00, 8'hC3}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            if (r[15] ^ b[k]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    task automatic push(input logic [7:0] b, input bit in_crc, inout logic [15:0] c);
        exp_b[exp_n] = b;
        exp_n++;
        if (in_crc) c = crc_upd(c, b);
    endtask

    task automatic build(input int pre_n, input bit tgt, input bit err, input bit wr,
                         input logic [4:0] len, input logic [7:0] code,
                         input bit crcen, input logic [7:0] seed);
        logic [15:0] c;
        c = 16'hFFFF;
        exp_n = 0;
        for (int i = 0; i < pre_n; i++) push(8'hFE, 1'b0, c);
        push(8'h68, 1'b1, c);
        if (tgt) push(8'hAD, 1'b1, c);
        push({err, 2'b00, (err || wr) ? 5'd0 : len}, 1'b1, c);
        if (err)     push(code, 1'b1, c);
        else if (wr) push(8'hAC, 1'b1, c);
        else for (int i = 0; i <= int'(len); i++) push(pat(seed, i), 1'b1, c);
        if (crcen) begin
            push(c[7:0], 1'b0, c);
            push(c[15:8], 1'b0, c);
        end
        push(8'h16, 1'b0, c);
    endtask

    task automatic run_frame(input bit sel, input bit err, input bit wr, input bit crcen,
                             input logic [4:0] len, input logic [7:0] code,
                             input logic [7:0] seed, input bit inject, input string tag);
        int hold_bad, mism, ctrl_pos, pre_n;
        bit prev_stall, seen_done, valid_at_done;
        logic [7:0] prev_b;
        bit cv, cd;
        logic [7:0] cb;
        pre_n = sel ? 2 : 0;
        build(pre_n, !sel, err, wr, len, code, crcen, seed);
        r_err = err; r_wr = wr; r_crc = crcen; r_len = len; r_code = code;
        for (int i = 0; i < 32; i++) r_data[i*8 +: 8] = pat(seed, i);
        if (sel) rv_p = 1'b1; else rv_m = 1'b1;
        @(negedge clk);
        rv_p = 1'b0; rv_m = 1'b0;
        got_n = 0; hold_bad = 0; prev_stall = 0; prev_b = '0;
        seen_done = 0; valid_at_done = 0;
        for (int it = 0; it < 600; it++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            t_rdy = lfsr[0] | lfsr[1];
            if (inject && it == 3) begin
                r_err = 1'b1; r_code = 8'hE2; r_data = ~r_data; r_crc = ~crcen;
                if (sel) rv_p = 1'b1; else rv_m = 1'b1;
            end
            if (inject && it == 4) begin
                rv_p = 1'b0; rv_m = 1'b0;
            end
            #1;
            cv = sel ? tv_p : tv_m;
            cb = sel ? td_p : td_m;
            cd = sel ? dn_p : dn_m;
            if (cd) begin
                seen_done = 1;
                valid_at_done = cv;
                break;
            end
            if (prev_stall && !(cv && cb == prev_b)) hold_bad++;
            if (cv && t_rdy && got_n < 64) begin
                got_b[got_n] = cb;
                got_n++;
            end
            prev_stall = cv && !t_rdy;
            prev_b = cb;
            @(negedge clk);
        end
        rv_p = 1'b0; rv_m = 1'b0;
        mism = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (mism < 0 && got_b[i] !== exp_b[i]) mism = i;
        check(got_n == exp_n, tag, "frame length", got_n, exp_n);
        if (mism >= 0)
            check(1'b0, tag, $sformatf("byte %0d", mism), got_b[mism], exp_b[mism]);
        else
            check(1'b1, tag, "frame bytes", 0, 0);
        ctrl_pos = pre_n + (sel ? 1 : 2);
        check(got_b[ctrl_pos] == exp_b[ctrl_pos], "R3", "control byte",
              got_b[ctrl_pos], exp_b[ctrl_pos]);
        check(hold_bad == 0, "R9", "stalled byte held", hold_bad, 0);
        check(seen_done && !valid_at_done, "R10", "done pulse with valid low",
              {seen_done, valid_at_done}, 2'b10);
        @(negedge clk);
        #1;
        check((sel ? dn_p : dn_m) == 1'b0, "R10", "done lasts one cycle",
              sel ? dn_p : dn_m, 0);
        if (inject) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); #1;
                check((sel ? tv_p : tv_m) == 1'b0, "R11", "no frame from busy request",
                      sel ? tv_p : tv_m, 0);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(tv_m == 1'b0, "R1", "tx_valid after reset", tv_m, 0);
        check(dn_m == 1'b0, "R1", "done after reset", dn_m, 0);
        check(rr_m == 1'b1, "R1", "req_ready after reset", rr_m, 1);
        @(negedge clk);

        // Vector table: R2 R4 R5 R6 R7 across reads, writes and errors
        for (int v = 0; v < NV; v++) begin
            logic [27:0] e;
            string tag;
            e = VEC[v];
            tag = e[27] ? "R2 R6 R7" : (e[26] ? "R2 R5 R7" : "R2 R4 R7");
            run_frame(1'b0, e[27], e[26], e[25], e[24:20], e[15:8], e[7:0], 1'b0, tag);
        end

        // R8 filler bytes kept out of the CRC, no target byte
        run_frame(1'b1, 1'b0, 1'b0, 1'b1, 5'd1, 8'h00, 8'h90, 1'b0, "R8 R7");
        run_frame(1'b1, 1'b1, 1'b0, 1'b0, 5'd6, 8'hE2, 8'h91, 1'b0, "R8 R6");

        // R11 request and data changes mid-frame are ignored
        run_frame(1'b0, 1'b0, 1'b0, 1'b1, 5'd5, 8'h00, 8'h77, 1'b1, "R11");
        run_frame(1'b1, 1'b0, 1'b1, 1'b1, 5'd2, 8'h00, 8'h78, 1'b1, "R11");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule